// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus that a MAC uses to reach registers inside external PHYs. Software programs two 32-bit registers through a plain write/read port. The data register holds the 16-bit value to send or receive and, for extended addressing, a 16-bit register address in its upper half. The command register holds a start/busy flag, the framing choice, a direction code, the PHY address, a register or device number, and a divider select for the management clock.

Setting the busy flag, with a valid direction code, starts a transaction. The block shifts the frame out on the management clock and data pins, releases the data pin for the reply on reads, and stores the returned 16 bits. It clears busy when the transaction is done. In the basic (Clause 22) framing one frame carries the whole access. In the extended (Clause 45) framing the block first sends an address frame and then the access frame, and busy stays set across both. The data pin is a split tri-state: an output value, an output enable and a sampled input.

Top module: `mdio_master`

## Requirements
- R1: A synchronous reset clears busy, holds MDC low, releases MDIO (output enable low), and makes both registers read as zero.
- R2: A command write (`reg_sel`=0) while idle starts a transaction only when bit 0 is 1 and the direction field in bits 3:2 is 01 (write) or 11 (read). Busy then reads as 1 from the next cycle. With bit 0 set and a direction field of 00 or 10, busy stays 0 and no frame is sent.
- R3: The divider select in command bits 10:8, value s, keeps MDC high for 2^s clock cycles per bit. MDC is low whenever the block is idle.
- R4: With command bit 1 clear, a write sends a single 64-bit frame, MSB first, one bit per MDC period. The frame is 32 ones, start 01, opcode 01, the PHY address (command bits 20:16), the register number (command bits 25:21), turnaround 10, then data bits 15:0. MDIO changes only while MDC is low.
- R5: With command bit 1 clear, a read sends 32 ones, start 01, opcode 10, the PHY address and the register number. MDIO is released from the first turnaround bit to the end of the frame. The first turnaround bit is ignored, and 16 bits are sampled MSB first on MDC rising edges into data bits 15:0.
- R6: With command bit 1 set, a write sends two frames. The first is 32 ones, start 00, opcode 00, the PHY address, the device address (command bits 25:21), turnaround 10 and data bits 31:16. The second has the same header with opcode 01 and carries data bits 15:0.
- R7: With command bit 1 set, a read sends the same address frame, then a frame with start 00 and opcode 11 that is released from turnaround on. The reply lands in data bits 15:0, and data bits 31:16 keep their value.
- R8: Busy stays set until the MDC falling edge that ends the last frame, so exactly one frame (command bit 1 clear) or two frames (command bit 1 set) go out per start.
- R9: While busy, writes to either register are ignored. After completion the command fields and the write data read back unchanged, and no new transaction starts.
- R10: `reg_rdata` returns the data register when `reg_sel`=1. When `reg_sel`=0 it returns the command register: busy in bit 0, the stored fields at their positions, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO sampled input |

## Verification
A wrong bit counter or frame select shows up at the pins within one frame. The scoreboard compares every captured 64-bit frame and its enable pattern, so a shifted field, a wrong start or opcode pair, or a turnaround driven when it should be released is reported when that frame ends. A fault in the busy or phase state shows up as a wrong frame count when busy clears: one frame for an extended access, or a second frame for a basic one. A fault in the capture path shows up in the data read back right after completion. A wrong divider count is reported at the end of the first frame that uses that select value.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CSEL_W   = 3,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_W = PRE_BITS + 32;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int HALF_W  = 1 << CSEL_W;

  logic              busy, c45, second;
  logic [1:0]        op;
  logic [CSEL_W-1:0] csel;
  logic [4:0]        phy, regf;
  logic [31:0]       data_q, cmd_rd;
  logic [IDX_W-1:0]  bit_idx;
  logic [HALF_W-1:0] div_cnt, half_m1;
  logic [1:0]        st_w, op_w;
  logic [15:0]       payload;
  logic [FRAME_W-1:0] frame;
  logic              addr_phase, rd_frame, released, tick, rise, fall, last, cur_bit;
  logic              unused_bits;

  assign addr_phase = c45 && !second;
  assign rd_frame   = (op == 2'b11) && !addr_phase;
  assign st_w       = c45 ? 2'b00 : 2'b01;
  assign op_w       = addr_phase ? 2'b00 : c45 ? op : (op == 2'b11 ? 2'b10 : 2'b01);
  assign payload    = addr_phase ? data_q[31:16] : data_q[15:0];
  assign frame      = {{PRE_BITS{1'b1}}, st_w, op_w, phy, regf, 2'b10, payload};
  assign cur_bit    = frame[IDX_W'(FRAME_W - 1) - bit_idx];
  assign released   = rd_frame && (bit_idx >= IDX_W'(PRE_BITS + 14));
  assign mdio_oe    = busy && !released;
  assign mdio_o     = mdio_oe && cur_bit;

  assign half_m1 = (HALF_W'(1) << csel) - HALF_W'(1);
  assign tick    = busy && (div_cnt == half_m1);
  assign rise    = tick && !mdc;
  assign fall    = tick && mdc;
  assign last    = bit_idx == IDX_W'(FRAME_W - 1);

  always_comb begin
    cmd_rd             = '0;
    cmd_rd[0]          = busy;
    cmd_rd[1]          = c45;
    cmd_rd[3:2]        = op;
    cmd_rd[8 +: CSEL_W] = csel;
    cmd_rd[20:16]      = phy;
    cmd_rd[25:21]      = regf;
  end
  assign reg_rdata = reg_sel ? data_q : cmd_rd;

  assign unused_bits = ^{reg_wdata[31:26], reg_wdata[15:11], reg_wdata[7:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      c45     <= 1'b0;
      second  <= 1'b0;
      op      <= '0;
      csel    <= '0;
      phy     <= '0;
      regf    <= '0;
      data_q  <= '0;
      bit_idx <= '0;
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else if (!busy) begin
      if (reg_we && !reg_sel) begin
        c45     <= reg_wdata[1];
        op      <= reg_wdata[3:2];
        csel    <= reg_wdata[8 +: CSEL_W];
        phy     <= reg_wdata[20:16];
        regf    <= reg_wdata[25:21];
        busy    <= reg_wdata[0] && reg_wdata[2];
        second  <= 1'b0;
        bit_idx <= '0;
        div_cnt <= '0;
        mdc     <= 1'b0;
      end
      if (reg_we && reg_sel) data_q <= reg_wdata;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + HALF_W'(1);
      if (tick) mdc <= !mdc;
      if (rise && rd_frame && bit_idx >= IDX_W'(PRE_BITS + 16))
        data_q[15:0] <= {data_q[14:0], mdio_i};
      if (fall) begin
        if (last) begin
          bit_idx <= '0;
          if (addr_phase) second <= 1'b1;
          else            busy   <= 1'b0;
        end else begin
          bit_idx <= bit_idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int CSEL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic              reg_sel,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              c45,
  input logic [1:0]        op,
  input logic [CSEL_W-1:0] csel,
  input logic [4:0]        phy,
  input logic [4:0]        regf,
  input logic [31:0]       data_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $fell(rst) |-> (!busy && !mdc && !mdio_oe));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_we && !reg_sel && reg_wdata[0] && reg_wdata[2]) |=> busy);
  // R2
  start_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_we && !reg_sel && !reg_wdata[2]) |=> !busy);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mdc && !mdio_oe));
  // R3
  mdc_owner_chk: assert property (@(posedge clk) disable iff (rst) $rose(mdc) |-> busy);
  // R4
  mdio_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && !reg_sel) |=> $stable({c45, op, csel, phy, regf}));
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_sel) |=> $stable(data_q[31:16]));
endmodule

bind mdio_master mdio_master_chk #(.CSEL_W(CSEL_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .c45(c45), .op(op),
  .csel(csel), .phy(phy), .regf(regf), .data_q(data_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0, rst = 1'b1, reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        resp_drv = 1'b1;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign mdio_i = mdio_oe ? mdio_o : resp_drv;

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  logic [63:0] exp_v_q[$];
  logic [63:0] exp_o_q[$];
  string       exp_tag_q[$];

  logic        mdc_d = 1'b0, half_bad = 1'b0;
  int          bitn = 0, hi_cnt = 0, frames_seen = 0, cur_half = 1;
  logic [63:0] cap_v = '0, cap_o = '0;
  logic [3:0]  stop = '0;
  logic [15:0] resp_data = '0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_frame();
    logic [63:0] ev, eo;
    string tg;
    frames_seen++;
    checks++;
    if (exp_v_q.size() == 0) begin
      errors++;
      $display("FAIL R8: unexpected frame actual v=%h oe=%h expected none", cap_v, cap_o);
    end else begin
      ev = exp_v_q.pop_front();
      eo = exp_o_q.pop_front();
      tg = exp_tag_q.pop_front();
      if (cap_v !== ev || cap_o !== eo) begin
        errors++;
        $display("FAIL %s: frame actual v=%h oe=%h expected v=%h oe=%h", tg, cap_v, cap_o, ev, eo);
      end
    end
    checks++;
    if (half_bad) begin
      errors++;
      $display("FAIL R3: MDC high phase actual=mismatch expected=%0d cycles", cur_half);
    end
    half_bad = 1'b0;
  endtask

  // monitor and PHY responder
  always @(negedge clk) begin
    if (rst) begin
      mdc_d = 1'b0; bitn = 0; hi_cnt = 0; resp_drv = 1'b1; half_bad = 1'b0;
    end else begin
      if (mdc) hi_cnt++;
      if (mdc && !mdc_d) begin
        cap_v = {cap_v[62:0], mdio_oe & mdio_o};
        cap_o = {cap_o[62:0], mdio_oe};
        bitn++;
        if (bitn == 36) stop = cap_v[3:0];
      end else if (!mdc && mdc_d) begin
        if (hi_cnt != cur_half) half_bad = 1'b1;
        hi_cnt = 0;
        if (bitn == 64) begin
          finish_frame();
          bitn = 0;
          resp_drv = 1'b1;
        end else if (bitn >= 47 && (stop == 4'b0110 || stop == 4'b0011)) begin
          resp_drv = (bitn == 47) ? 1'b0 : resp_data[63 - bitn];
        end
      end
      mdc_d = mdc;
    end
  end

  task automatic write_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] rb;
    rb = 32'h1;
    while (rb[0]) read_reg(1'b0, rb);
  endtask

  task automatic push(input logic [63:0] v, input logic [63:0] o, input string tg);
    exp_v_q.push_back(v);
    exp_o_q.push_back(o);
    exp_tag_q.push_back(tg);
  endtask

  function automatic logic [31:0] mk_cmd(input logic c45, input logic rd, input logic [4:0] phy,
                                        input logic [4:0] rf, input logic [2:0] cs);
    return {6'b0, rf, phy, 5'b0, cs, 4'b0, (rd ? 2'b11 : 2'b01), c45, 1'b1};
  endfunction

  task automatic run_op(input logic c45, input logic rd, input logic [4:0] phy, input logic [4:0] rf,
                        input logic [2:0] cs, input logic [15:0] a16, input logic [15:0] wd,
                        input logic [15:0] rsp, input string tg);
    logic [31:0] rb;
    int f0, nf;
    cur_half = 1 << cs;
    resp_data = rsp;
    if (c45) push({32'hFFFF_FFFF, 2'b00, 2'b00, phy, rf, 2'b10, a16}, '1, tg);
    if (rd) push({32'hFFFF_FFFF, (c45 ? 4'b0011 : 4'b0110), phy, rf, 18'h0}, 64'hFFFF_FFFF_FFFC_0000, tg);
    else    push({32'hFFFF_FFFF, (c45 ? 4'b0001 : 4'b0101), phy, rf, 2'b10, wd}, '1, tg);
    nf = c45 ? 2 : 1;
    f0 = frames_seen;
    write_reg(1'b1, {a16, wd});
    write_reg(1'b0, mk_cmd(c45, rd, phy, rf, cs));
    read_reg(1'b0, rb);
    check(rb[0] == 1'b1, "R2 busy after start", {31'b0, rb[0]}, 32'h1);
    wait_idle();
    check((frames_seen - f0) == nf, "R8 frame count", 32'(frames_seen - f0), 32'(nf));
    if (rd) begin
      read_reg(1'b1, rb);
      check(rb[15:0] == rsp, c45 ? "R7 read data" : "R5 read data", {16'h0, rb[15:0]}, {16'h0, rsp});
      check(rb[31:16] == a16, c45 ? "R7 upper data kept" : "R10 upper data", {16'h0, rb[31:16]}, {16'h0, a16});
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8: watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rb, c9;
    int f0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1
    read_reg(1'b0, rb); check(rb == 32'h0, "R1 command after reset", rb, 32'h0);
    read_reg(1'b1, rb); check(rb == 32'h0, "R1 data after reset", rb, 32'h0);
    check({mdc, mdio_oe} == 2'b00, "R1 pins after reset", {30'b0, mdc, mdio_oe}, 32'h0);
    // R10
    write_reg(1'b0, 32'hFFFF_FFFE);
    read_reg(1'b0, rb); check(rb == 32'h03FF_070E, "R10 command readback", rb, 32'h03FF_070E);
    write_reg(1'b1, 32'hA5A5_1234);
    read_reg(1'b1, rb); check(rb == 32'hA5A5_1234, "R10 data readback", rb, 32'hA5A5_1234);
    // R2 rejected direction codes
    f0 = frames_seen;
    write_reg(1'b0, 32'h0000_0001);
    read_reg(1'b0, rb); check(rb[0] == 1'b0, "R2 op 00 no start", {31'b0, rb[0]}, 32'h0);
    write_reg(1'b0, 32'h0000_0009);
    read_reg(1'b0, rb); check(rb[0] == 1'b0, "R2 op 10 no start", {31'b0, rb[0]}, 32'h0);
    repeat (100) @(negedge clk);
    check(frames_seen == f0, "R2 no frame", 32'(frames_seen), 32'(f0));
    check(mdc == 1'b0, "R3 MDC idle low", {31'b0, mdc}, 32'h0);
    // R4, R5, R6, R7
    run_op(1'b0, 1'b0, 5'd5,  5'h1A, 3'd0, 16'h0000, 16'hBEEF, 16'h0000, "R4 basic write");
    run_op(1'b0, 1'b1, 5'h1F, 5'h00, 3'd1, 16'h0000, 16'h0000, 16'h8001, "R5 basic read");
    run_op(1'b0, 1'b1, 5'h0A, 5'h15, 3'd0, 16'h0000, 16'h0000, 16'h0000, "R5 basic read zero");
    run_op(1'b1, 1'b0, 5'd3,  5'h1E, 3'd2, 16'h1234, 16'h5678, 16'h0000, "R6 extended write");
    run_op(1'b1, 1'b1, 5'h10, 5'd7,  3'd0, 16'hFFFF, 16'h0000, 16'h0F0F, "R7 extended read");
    // R9 writes while busy
    cur_half = 8;
    push({32'hFFFF_FFFF, 4'b0101, 5'd2, 5'd9, 2'b10, 16'h1357}, '1, "R9 frame kept");
    c9 = mk_cmd(1'b0, 1'b0, 5'd2, 5'd9, 3'd3);
    f0 = frames_seen;
    write_reg(1'b1, 32'h0000_1357);
    write_reg(1'b0, c9);
    repeat (20) @(negedge clk);
    write_reg(1'b1, 32'hFFFF_0000);
    write_reg(1'b0, 32'h03FF_000F);
    wait_idle();
    read_reg(1'b1, rb); check(rb == 32'h0000_1357, "R9 data kept", rb, 32'h0000_1357);
    read_reg(1'b0, rb); check(rb == (c9 & ~32'h1), "R9 command kept", rb, c9 & ~32'h1);
    repeat (200) @(negedge clk);
    check((frames_seen - f0) == 1, "R9 no extra start", 32'(frames_seen - f0), 32'h1);
    check(exp_v_q.size() == 0, "R8 scoreboard drained", 32'(exp_v_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule